// File: doc/BRIEF.md
# Timed-Access Guard for the Program-Memory Size Register

This block sits on a simple special-function-register write bus (address, data, write strobe) and protects one register: the 3-bit on-chip program-memory size field. That field drives the memory decoder.

Software can change the field only after a two-step unlock. It writes AAh and then 55h to a dedicated unlock register. This opens a short window, and one write to the protected register may land inside it. The window closes on the first protected write, or when a fixed count of cycles runs out. Writes to every other register address pass straight through to the rest of the register file, with no unlock needed.

Masking interrupts around the change is left to software. The stored size code becomes effective as soon as it is written, so the fetch that follows the write already sees the new map.

Top module: `tacc_guard`

## Requirements
- R1: While reset is asserted, and right after it is released, mem_size reads 3'b111 (the largest on-chip size). The unlock sequencer is idle and the window is closed.
- R2: A write of AAh to the unlock address (C7h) followed by a write of 55h to that address opens the access window.
- R3: Once the 55h write has been taken, a protected write is honoured if it is presented in any of the 4 following cycles. From the 5th following cycle on, the window is closed.
- R4: A write to the protected address (C2h) while the window is closed is ignored, and mem_size keeps its value.
- R5: An honoured protected write stores wr_data[2:0] into the field, and mem_size shows it in the cycle after the write. wr_data[7:3] have no effect.
- R6: While the sequencer waits for 55h, any other value written to C7h returns it to idle; this includes a second AAh. Writes to other addresses leave it waiting. A 55h written while idle opens nothing.
- R7: The first honoured protected write closes the window, so a second protected write in the same window is ignored.
- R8: A write to any address other than C2h and C7h appears on fwd_wr_en in the same cycle, with its address and data. Writes to C2h or C7h never assert fwd_wr_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| mem_size | output | 3 | Stored program-memory size code, to the memory decoder |
| fwd_wr_en | output | 1 | Write strobe for unprotected registers |
| fwd_addr | output | 8 | Forwarded write address |
| fwd_data | output | 8 | Forwarded write data |

## Verification
The bench builds the guard with its default parameters: an 8-bit bus, unlock address C7h, protected address C2h, a key pair of AAh/55h and a 4-cycle window. A window this short lets the bench drive protected writes on the last cycle of the window and on the first cycle after it, in back-to-back sequences. The bench also covers aborted key pairs, unrelated writes placed between the two key bytes, reuse of an already consumed window, and a reset applied while the window is open.

// File: rtl/tacc_pkg.sv
package tacc_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/tacc_seq.sv
module tacc_seq
  import tacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              unlock_pulse
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    unlock_pulse = 1'b0;
    if (key_wr) begin
      unique case (state_q)
        SEQ_IDLE: if (key_data == KEY_A) state_d = SEQ_WAIT;
        SEQ_WAIT: begin
          state_d      = SEQ_IDLE;
          unlock_pulse = (key_data == KEY_B);
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R6: a wrong byte while waiting drops the sequence
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_WAIT && key_wr && key_data != KEY_B) |=> (state_q == SEQ_IDLE));
  // R2: the unlock only follows a wait state
  p_unlock_after_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |-> (state_q == SEQ_WAIT));
endmodule

// File: rtl/tacc_window.sv
module tacc_window #(
  parameter int WINDOW = 4,
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic consume,
  output logic open
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign open = (cnt_q != '0);

  always_comb begin
    cnt_en = reload | consume | open;
    cnt_d  = cnt_q;
    if (reload)       cnt_d = CNT_W'(WINDOW);
    else if (consume) cnt_d = '0;
    else if (open)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: the count never exceeds the window length
  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WINDOW));
  // R7: a consuming write closes the window
  p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !reload) |=> !open);
  // R2: the window opens only through a reload
  p_open_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(reload));
endmodule

// File: rtl/tacc_field.sv
module tacc_field #(
  parameter int FIELD_W = 3,
  parameter logic [FIELD_W-1:0] RESET_VAL = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] din,
  output logic [FIELD_W-1:0] q
);
  logic [FIELD_W-1:0] q_d;

  always_comb q_d = load ? din : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL;
    else if (load) q <= q_d;
  end

  // R5: a load lands on the next cycle
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));
  // R4: without a load the field holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/tacc_guard.sv
module tacc_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int FIELD_W = 3,
  parameter int WINDOW = 4,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'hC7,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'hC2,
  parameter logic [DATA_W-1:0] KEY_A = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FIELD_W-1:0] mem_size,
  output logic              fwd_wr_en,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data
);
  logic hit_unlock, hit_prot, unlock_pulse, win_open, prot_load;

  assign hit_unlock = wr_en && (wr_addr == UNLOCK_ADDR);
  assign hit_prot   = wr_en && (wr_addr == PROT_ADDR);
  assign prot_load  = hit_prot && win_open;

  assign fwd_wr_en = wr_en && !hit_unlock && !hit_prot;
  assign fwd_addr  = wr_addr;
  assign fwd_data  = wr_data;

  tacc_seq #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_wr(hit_unlock), .key_data(wr_data),
    .unlock_pulse(unlock_pulse));

  tacc_window #(.WINDOW(WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n), .reload(unlock_pulse), .consume(prot_load),
    .open(win_open));

  tacc_field #(.FIELD_W(FIELD_W), .RESET_VAL('1)) u_field (
    .clk(clk), .rst_n(rst_n), .load(prot_load), .din(wr_data[FIELD_W-1:0]),
    .q(mem_size));

  // R8: guarded addresses never leak to the forwarded bus
  p_fwd_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wr_en |-> (wr_addr != UNLOCK_ADDR && wr_addr != PROT_ADDR));
  // R4: a protected write outside the window leaves the field
  p_closed_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_prot && !win_open) |=> $stable(mem_size));
endmodule

// File: tb/tacc_guard_tb.sv
module tacc_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [2:0] mem_size;
  logic       fwd_wr_en;
  logic [7:0] fwd_addr, fwd_data;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct { logic [2:0] size; string req; } exp_t;
  exp_t sb_q[$];

  // independent reference state
  logic [2:0] m_size;
  bit         m_wait;
  int         m_win;

  always #2 clk = ~clk;

  tacc_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_size(mem_size), .fwd_wr_en(fwd_wr_en), .fwd_addr(fwd_addr), .fwd_data(fwd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare the field after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.req, {29'd0, mem_size}, {29'd0, e.size});
    end
  end

  // driver: one bus cycle, the model updated as the requirements state
  task automatic cyc(input bit en, input logic [7:0] a, input logic [7:0] d, input string req);
    bit pu, pp, hon, fw;
    exp_t e;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    pu = en && a == 8'hC7;
    pp = en && a == 8'hC2;
    fw = en && !pu && !pp;
    #1;
    chk("R8 fwd_wr_en", {31'd0, fwd_wr_en}, {31'd0, fw});
    if (fw) chk("R8 fwd addr/data", {16'd0, fwd_addr, fwd_data}, {16'd0, a, d});
    hon = pp && m_win > 0;
    if (hon) m_size = d[2:0];
    if (pu && m_wait && d == 8'h55) m_win = 4;
    else if (hon)                   m_win = 0;
    else if (m_win > 0)             m_win = m_win - 1;
    if (pu) m_wait = m_wait ? 1'b0 : (d == 8'hAA);
    @(posedge clk);
    e.size = m_size; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 8'h00, req);
  endtask

  task automatic unlock(input string req);
    cyc(1'b1, 8'hC7, 8'hAA, req);
    cyc(1'b1, 8'hC7, 8'h55, req);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; rst_n = 0;
    m_size = 3'b111; m_wait = 0; m_win = 0;
    #9;
    chk("R1 reset value", {29'd0, mem_size}, 32'h7);
    @(negedge clk); rst_n = 1;
    idle(1, "R1 after reset");
    cyc(1'b1, 8'hC2, 8'h03, "R4 write without unlock");
    unlock("R2 unlock");
    cyc(1'b1, 8'hC2, 8'h03, "R2 R5 honoured write 011b");
    cyc(1'b1, 8'hC2, 8'h06, "R7 second write after consume");
    unlock("R3");
    idle(3, "R3");
    cyc(1'b1, 8'hC2, 8'h05, "R3 last window cycle");
    unlock("R3");
    idle(4, "R3");
    cyc(1'b1, 8'hC2, 8'h02, "R3 R4 window expired");
    cyc(1'b1, 8'hC7, 8'hAA, "R6");
    cyc(1'b1, 8'hC7, 8'h12, "R6");
    cyc(1'b1, 8'hC7, 8'h55, "R6");
    cyc(1'b1, 8'hC2, 8'h01, "R6 aborted by wrong byte");
    cyc(1'b1, 8'hC7, 8'hAA, "R6");
    cyc(1'b1, 8'hC7, 8'hAA, "R6");
    cyc(1'b1, 8'hC7, 8'h55, "R6");
    cyc(1'b1, 8'hC2, 8'h01, "R6 aborted by repeated AAh");
    cyc(1'b1, 8'hC7, 8'h55, "R6 55h while idle");
    cyc(1'b1, 8'hC2, 8'h01, "R6 no window from lone 55h");
    cyc(1'b1, 8'hC7, 8'hAA, "R6");
    cyc(1'b1, 8'h80, 8'h3C, "R6 R8 other address while waiting");
    cyc(1'b1, 8'hC7, 8'h55, "R6");
    cyc(1'b1, 8'hC2, 8'h00, "R6 write after interleaved unlock");
    unlock("R5");
    cyc(1'b1, 8'hC2, 8'hF9, "R5 upper data bits ignored");
    cyc(1'b1, 8'hE0, 8'hC2, "R8 forward");
    cyc(1'b1, 8'h00, 8'hFF, "R8 forward");
    unlock("R1");
    @(negedge clk); rst_n = 0;
    #1;
    chk("R1 reset mid-window", {29'd0, mem_size}, 32'h7);
    sb_q.delete();
    m_size = 3'b111; m_wait = 0; m_win = 0;
    @(negedge clk); rst_n = 1;
    cyc(1'b1, 8'hC2, 8'h02, "R1 window closed after reset");
    idle(2, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule